// File: doc/BRIEF.md
# Top-Octave Tone Divider Bank

This block turns one master clock into thirteen square waves, one for each semitone of the highest octave of an electronic organ keyboard. Every output has its own free-running counter with a fixed integer divisor. The divisors step by roughly the twelfth root of two, so the outputs form an equal-tempered chromatic scale. The divisors run from 478 on output 0, the lowest note, down to 239 on output 12, one octave higher. With a master clock of about 2.00024 MHz, output 12 sits near 8.37 kHz. Octave dividers further down the chain take these waves as their source.

Two static choices shape the bank. The elaboration parameter `FULL_SET` selects the thirteen-output build (1) or the twelve-output build (0). The twelve-output build has no counter behind output 12. The input `duty30` selects the pulse shape on every output. At 0, the output is high for half the period, rounded down. At 1, the output is high for 30 percent of the period, rounded to the nearest clock. The divisors are the same in both shapes. `duty30` is meant to change only while reset is held. A synchronous reset clears every counter and lines up all the outputs, so that every active output starts its first high phase on the same edge.

Top module: `tone_bank`

## Requirements
- R1: Output k (k = 0 to 12) repeats with a period of exactly N_k master clocks, rising edge to rising edge. The divisors, in output order, are N = 478, 451, 426, 402, 379, 358, 338, 319, 301, 284, 268, 253, 239.
- R2: With `duty30` = 0, each active output stays high for floor(N_k/2) clocks and low for the remaining clocks of its period.
- R3: With `duty30` = 1, each active output stays high for round(0.3·N_k) clocks, computed as (3·N_k+5)/10 in integer arithmetic. The period stays N_k.
- R4: While `rst` is high, every output is low. One clock edge with `rst` high is enough to clear all outputs, and they read low right after that edge.
- R5: On the first clock edge after `rst` goes low, all active outputs go high together. Outputs 0 to 12 go high when `FULL_SET` = 1, and outputs 0 to 11 go high when `FULL_SET` = 0.
- R6: With `FULL_SET` = 0, output 12 stays low at all times. Outputs 0 to 11 behave exactly as they do in the thirteen-output build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| duty30 | input | 1 | Pulse shape select: 0 gives half duty, 1 gives 30 percent duty (static, changed only under reset) |
| tone_out | output | 13 | Tone outputs, bit k carries divisor N_k |

## Verification
Each output comes from a register. A change on `rst` is therefore visible on `tone_out` one edge later: the outputs read low after the first reset edge, and read high after the first edge without reset. The bench drives its inputs on the falling clock edge and samples one falling edge later, which lands exactly on the cycle where each result is due. High times and periods are counted in whole clocks between sampled transitions, over at least two full periods of the slowest output. The expected values come from the divisor table given in the requirements. The checks cover both pulse shapes and a return to half duty, on the thirteen-output build and the twelve-output build running side by side.

// File: rtl/tone_pkg.sv
package tone_pkg;
   // Number of tone outputs in the full bank
   localparam int MAX_TONES = 13;
   // Outputs driven in the reduced bank
   localparam int SHORT_TONES = 12;
   // Largest divisor in the set, sizes the counters
   localparam int MAX_DIV = 478;
   localparam int CNT_W = $clog2(MAX_DIV + 1);

   // Divisor for output idx; output 0 is the lowest note
   function automatic int tone_divisor(input int idx);
      case (idx)
         0:  return 478;
         1:  return 451;
         2:  return 426;
         3:  return 402;
         4:  return 379;
         5:  return 358;
         6:  return 338;
         7:  return 319;
         8:  return 301;
         9:  return 284;
         10: return 268;
         11: return 253;
         default: return 239;
      endcase
   endfunction

   // High clocks in half-duty shape: floor(n/2)
   function automatic int high_half(input int n);
      return n / 2;
   endfunction

   // High clocks in 30 percent shape: round(0.3 n)
   function automatic int high_thirty(input int n);
      return (3 * n + 5) / 10;
   endfunction
endpackage

// File: rtl/tone_counter.sv
module tone_counter #(
   parameter int DIV = 239,
   parameter int W   = 9
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   initial begin
      assert (DIV >= 2 && DIV < (1 << W))
         else $error("tone_counter: divisor %0d does not fit %0d bits", DIV, W);
   end

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (count == LAST)
         count <= '0;
      else
         count <= count + 1'b1;
   end
endmodule

// File: rtl/tone_shaper.sv
module tone_shaper #(
   parameter int HI_HALF   = 119,
   parameter int HI_THIRTY = 72,
   parameter int W         = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         duty30,
   input  logic [W-1:0] count,
   output logic         wave
);
   localparam logic [W-1:0] LIM_HALF   = W'(HI_HALF);
   localparam logic [W-1:0] LIM_THIRTY = W'(HI_THIRTY);

   logic [W-1:0] limit;

   initial begin
      assert (HI_HALF >= 1 && HI_THIRTY >= 1)
         else $error("tone_shaper: high count must be at least one");
   end

   assign limit = duty30 ? LIM_THIRTY : LIM_HALF;

   always_ff @(posedge clk) begin
      if (rst)
         wave <= 1'b0;
      else
         wave <= (count < limit);
   end
endmodule

// File: rtl/tone_bank.sv
module tone_bank
   import tone_pkg::*;
#(
   parameter int FULL_SET = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 duty30,
   output logic [MAX_TONES-1:0] tone_out
);
   localparam int ACTIVE = (FULL_SET != 0) ? MAX_TONES : SHORT_TONES;

   initial begin
      assert (FULL_SET == 0 || FULL_SET == 1)
         else $error("tone_bank: FULL_SET must be 0 or 1, got %0d", FULL_SET);
   end

   for (genvar i = 0; i < MAX_TONES; i++) begin : g_voice
      if (i < ACTIVE) begin : g_live
         localparam int N = tone_divisor(i);
         logic [CNT_W-1:0] count;

         tone_counter #(
            .DIV (N),
            .W   (CNT_W)
         ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .count (count)
         );

         tone_shaper #(
            .HI_HALF   (high_half(N)),
            .HI_THIRTY (high_thirty(N)),
            .W         (CNT_W)
         ) u_shape (
            .clk    (clk),
            .rst    (rst),
            .duty30 (duty30),
            .count  (count),
            .wave   (tone_out[i])
         );
      end else begin : g_idle
         assign tone_out[i] = 1'b0;
      end
   end
endmodule

// File: rtl/tone_bank_chk.sv
module tone_bank_chk
   import tone_pkg::*;
#(
   parameter int FULL_SET = 1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 duty30,
   input logic [MAX_TONES-1:0] tone_out
);
   localparam int ACTIVE = (FULL_SET != 0) ? MAX_TONES : SHORT_TONES;
   localparam logic [MAX_TONES-1:0] LIVE_MASK = MAX_TONES'((1 << ACTIVE) - 1);

   // R4: outputs read low on the first edge after a reset edge
   assert_reset_low_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> tone_out == '0);

   // R5: all live outputs rise together after reset release
   assert_sync_start_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |=> tone_out == LIVE_MASK);

   if (FULL_SET == 0) begin : g_short
      assert_unused_low_R6: assert property (@(posedge clk) disable iff (rst)
         tone_out[MAX_TONES-1] == 1'b0);
   end

   for (genvar i = 0; i < ACTIVE; i++) begin : g_mon
      localparam int N = tone_divisor(i);
      localparam logic [9:0] PER_EXP = 10'(N);
      localparam logic [9:0] HI_H    = 10'(high_half(N));
      localparam logic [9:0] HI_T    = 10'(high_thirty(N));

      logic       prev;
      logic       seen;
      logic [9:0] per_cnt;
      logic [9:0] hi_cnt;
      logic       rise;
      logic       fall;

      assign rise = tone_out[i] & ~prev;
      assign fall = ~tone_out[i] & prev;

      always_ff @(posedge clk) begin
         if (rst) begin
            prev    <= 1'b0;
            seen    <= 1'b0;
            per_cnt <= '0;
            hi_cnt  <= '0;
         end else begin
            prev <= tone_out[i];
            if (rise) begin
               seen    <= 1'b1;
               per_cnt <= 10'd1;
               hi_cnt  <= 10'd1;
            end else begin
               per_cnt <= per_cnt + 10'd1;
               if (tone_out[i])
                  hi_cnt <= hi_cnt + 10'd1;
            end
         end
      end

      assert_period_R1: assert property (@(posedge clk) disable iff (rst)
         (rise && seen) |-> per_cnt == PER_EXP);

      assert_high_half_R2: assert property (@(posedge clk) disable iff (rst)
         (fall && !duty30) |-> hi_cnt == HI_H);

      assert_high_thirty_R3: assert property (@(posedge clk) disable iff (rst)
         (fall && duty30) |-> hi_cnt == HI_T);
   end
endmodule

bind tone_bank tone_bank_chk #(.FULL_SET(FULL_SET)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .duty30   (duty30),
   .tone_out (tone_out)
);

// File: tb/tone_bank_test.sv
`timescale 1ns/1ps
module tone_bank_test;
   localparam int NT = 13;
   localparam int NTRK = 2 * NT;

   typedef struct {
      int trk;
      int per;
      int hi;
      bit flat;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic duty30 = 1'b0;
   logic [NT-1:0] out_full;
   logic [NT-1:0] out_short;
   logic [NTRK-1:0] all_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit meas_on = 1'b0;

   int prev_v[NTRK];
   int seen_v[NTRK];
   int per_v[NTRK];
   int hi_v[NTRK];
   int pmin[NTRK];
   int pmax[NTRK];
   int hmin[NTRK];
   int hmax[NTRK];
   int nper[NTRK];
   int nhi[NTRK];
   int ever[NTRK];

   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   tone_bank #(.FULL_SET(1)) uut (
      .clk(clk), .rst(rst), .duty30(duty30), .tone_out(out_full));

   tone_bank #(.FULL_SET(0)) uut12 (
      .clk(clk), .rst(rst), .duty30(duty30), .tone_out(out_short));

   assign all_out = {out_short, out_full};

   function automatic int ref_div(input int k);
      int t[NT] = '{478, 451, 426, 402, 379, 358, 338, 319, 301, 284, 268, 253, 239};
      return t[k];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Monitor: measures every track on the falling edge
   always @(negedge clk) begin
      if (meas_on) begin
         for (int j = 0; j < NTRK; j++) begin
            int o;
            o = int'(all_out[j]);
            if (o == 1) ever[j] = 1;
            if (o == 1 && prev_v[j] == 0) begin
               if (seen_v[j] == 1) begin
                  if (per_v[j] < pmin[j]) pmin[j] = per_v[j];
                  if (per_v[j] > pmax[j]) pmax[j] = per_v[j];
                  nper[j]++;
               end
               seen_v[j] = 1;
               per_v[j] = 1;
               hi_v[j] = 1;
            end else begin
               per_v[j]++;
               if (o == 1) hi_v[j]++;
            end
            if (o == 0 && prev_v[j] == 1) begin
               if (hi_v[j] < hmin[j]) hmin[j] = hi_v[j];
               if (hi_v[j] > hmax[j]) hmax[j] = hi_v[j];
               nhi[j]++;
            end
            prev_v[j] = o;
         end
      end
   end

   task automatic clear_meas();
      for (int j = 0; j < NTRK; j++) begin
         prev_v[j] = 0; seen_v[j] = 0; per_v[j] = 0; hi_v[j] = 0;
         pmin[j] = 9999; pmax[j] = 0; hmin[j] = 9999; hmax[j] = 0;
         nper[j] = 0; nhi[j] = 0; ever[j] = 0;
      end
   endtask

   // Scoreboard: pop expected items and compare with measurements
   task automatic score(input bit d);
      string rq;
      rq = d ? "R3" : "R2";
      while (exp_q.size() > 0) begin
         exp_t e;
         int j;
         e = exp_q.pop_front();
         j = e.trk;
         if (e.flat) begin
            check(ever[j] == 0, "R6", $sformatf("output 12 of short bank high"), ever[j], 0);
         end else begin
            check(nper[j] >= 2 && pmin[j] == e.per && pmax[j] == e.per,
                  (j >= NT) ? "R6" : "R1",
                  $sformatf("period track %0d (min %0d)", j, pmin[j]), pmax[j], e.per);
            check(nhi[j] >= 2 && hmin[j] == e.hi && hmax[j] == e.hi, rq,
                  $sformatf("high time track %0d (min %0d)", j, hmin[j]), hmax[j], e.hi);
         end
      end
   endtask

   // Driver: one reset, one measured window, expected items queued
   task automatic run_mode(input bit d);
      @(negedge clk);
      rst = 1'b1;
      duty30 = d;
      @(negedge clk);
      check(all_out == '0, "R4", "outputs after one reset edge", int'(all_out), 0);
      repeat (2) @(negedge clk);
      check(all_out == '0, "R4", "outputs while reset held", int'(all_out), 0);
      clear_meas();
      meas_on = 1'b1;
      rst = 1'b0;
      @(negedge clk);
      check(out_full == 13'h1FFF, "R5", "full bank first edge", int'(out_full), 'h1FFF);
      check(out_short == 13'h0FFF, "R5", "short bank first edge", int'(out_short), 'h0FFF);
      for (int k = 0; k < NT; k++) begin
         exp_t e;
         int n;
         n = ref_div(k);
         e.trk = k; e.per = n; e.hi = d ? (3 * n + 5) / 10 : n / 2; e.flat = 1'b0;
         exp_q.push_back(e);
         e.trk = k + NT;
         e.flat = (k == NT - 1);
         exp_q.push_back(e);
      end
      repeat (1500) @(negedge clk);
      meas_on = 1'b0;
      score(d);
   endtask

   initial begin
      clear_meas();
      repeat (3) @(negedge clk);
      run_mode(1'b0);
      run_mode(1'b1);
      run_mode(1'b0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule